// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block is the transmit half of a clocked synchronous serial port. Software writes a byte into a holding register. The engine moves that byte into a separate shift register and sends it on `txd` as an 8-bit frame, least significant bit first. The frame is accompanied by a serial clock. Because the holding register and the shift register are separate, the next byte can be written while the current one is still on the line. Frames then follow each other with no idle time between them.

The serial clock has two sources, chosen by `ext_mode`. In internal mode the block drives the clock on `sck_out`, with one half-period for each `baud_tick` strobe. In external mode an incoming clock on `ext_sck_in` paces the bits; it is resynchronized inside the block, and `sck_out` stays high. Two flags report progress: `dre_flag` (holding register free) and `tend_flag` (line idle). Each flag can raise a level interrupt request through its own enable. Error flags from the receive side keep a new frame from starting.

Top module: `sync_tx_engine`

## Requirements
- R1: A write (`wr_en`=1 while `tx_en`=1) stores `wr_data` and clears `dre_flag` on the following clock edge.
- R2: When the engine copies the holding register into the shift register, `dre_flag` returns to 1 on that edge. From an idle line this happens one clock after the write. `irq_empty` is 1 whenever `dre_flag`=1 and `int_en_empty`=1.
- R3: A frame carries `wr_data` bit 0 first and bit 7 last. In internal mode `txd` changes only on a falling edge of `sck_out` and is stable across the rising edge.
- R4: In internal mode each frame produces exactly 8 rising edges on `sck_out`. Each clock half-period lasts one `baud_tick` period.
- R5: If the holding register is full when bit 7 ends, the next frame starts with no gap: rising edges stay exactly two tick periods apart, and `tend_flag` does not rise between the frames.
- R6: If the holding register is empty when bit 7 ends, `tend_flag` becomes 1 and `txd` keeps the level of bit 7.
- R7: `irq_end` is 1 whenever `tend_flag`=1 and `int_en_end`=1.
- R8: After reset `dre_flag`, `tend_flag`, `txd` and `sck_out` are 1, and `sck_out` stays high whenever the line is idle.
- R9: While `tx_en`=0 the engine is held idle: `dre_flag`=1, `tend_flag`=1 and `sck_out`=1. A write made in that state never starts a frame.
- R10: While any of `err_overrun`, `err_framing` or `err_parity` is 1, no frame starts and `dre_flag` stays 0. The pending byte is sent once the errors clear.
- R11: In external mode `ext_sck_in` is passed through a two-stage synchronizer. Each synchronized falling edge puts the next bit on `txd`, the rising edge after bit 7 ends the frame, and `sck_out` stays 1 throughout.
- R12: A write clears `tend_flag` on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; 0 holds the engine idle |
| ext_mode | input | 1 | 1 = take the serial clock from `ext_sck_in` |
| baud_tick | input | 1 | One-cycle strobe; each strobe is one internal clock half-period |
| ext_sck_in | input | 1 | External serial clock, asynchronous |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| err_overrun | input | 1 | Receive overrun error flag; inhibits start |
| err_framing | input | 1 | Receive framing error flag; inhibits start |
| err_parity | input | 1 | Receive parity error flag; inhibits start |
| int_en_empty | input | 1 | Enable for the holding-register-empty request |
| int_en_end | input | 1 | Enable for the transmit-end request |
| txd | output | 1 | Serial data |
| sck_out | output | 1 | Serial clock driven in internal mode, high when idle |
| dre_flag | output | 1 | Holding register free |
| tend_flag | output | 1 | Transmission ended, line idle |
| irq_empty | output | 1 | Holding-register-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
The hardest case is the back-to-back hand-off. A design that reloads through an idle state inserts a clock gap or briefly raises `tend_flag`; the bench measures the spacing of every rising edge and counts `tend_flag` rises across a three-byte burst. Line idle is checked with bytes whose bit 7 is 1 and 0: a design that returns `txd` to a fixed idle level fails one of them. The bench also checks gating. A write while errors are pending must not start until the errors clear, and a write while disabled must never be sent; a design that ignores either gate produces clock edges the bench counts. In external mode the bench supplies exactly eight pulses per frame. A design that ends the frame on the wrong edge, or drives `sck_out`, either leaves `tend_flag` low or pulls the pin low.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;

    // Engine phase: ST_ARM waits for the first falling step, ST_LOW and
    // ST_HIGH are the two clock half-periods of a bit.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } tx_state_e;

endpackage

// File: rtl/sync_tx_extclk.sv
module sync_tx_extclk #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_async,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_regs_t;

    sync_regs_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], sck_async};
        s_d.last = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sync: '1, last: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign rise = s_q.sync[STAGES-1] & ~s_q.last;
    assign fall = ~s_q.sync[STAGES-1] & s_q.last;

endmodule

// File: rtl/sync_tx_step.sv
module sync_tx_step
    import sync_tx_pkg::*;
(
    input  logic      ext_mode,
    input  logic      baud_tick,
    input  logic      ext_rise,
    input  logic      ext_fall,
    input  tx_state_e state,
    output logic      step
);

    logic fall_evt;
    logic rise_evt;

    always_comb begin
        fall_evt = ext_mode ? ext_fall : baud_tick;
        rise_evt = ext_mode ? ext_rise : baud_tick;
        unique case (state)
            ST_ARM, ST_HIGH: step = fall_evt;
            ST_LOW:          step = rise_evt;
            default:         step = 1'b0;
        endcase
    end

endmodule

// File: rtl/sync_tx_engine.sv
module sync_tx_engine
    import sync_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              ext_mode,
    input  logic              baud_tick,
    input  logic              ext_sck_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              err_overrun,
    input  logic              err_framing,
    input  logic              err_parity,
    input  logic              int_en_empty,
    input  logic              int_en_end,
    output logic              txd,
    output logic              sck_out,
    output logic              dre_flag,
    output logic              tend_flag,
    output logic              irq_empty,
    output logic              irq_end
);

    localparam int              CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] shift;
        logic [CNT_W-1:0]  bit_idx;
        logic              dre;
        logic              tend;
        logic              txd;
        logic              sck;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic             ext_rise;
    logic             ext_fall;
    logic             step;
    logic             err_any;
    logic             can_load;
    logic [CNT_W-1:0] nxt_idx;

    sync_tx_extclk #(
        .STAGES (SYNC_STAGES)
    ) u_extclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_async (ext_sck_in),
        .rise      (ext_rise),
        .fall      (ext_fall)
    );

    sync_tx_step u_step (
        .ext_mode  (ext_mode),
        .baud_tick (baud_tick),
        .ext_rise  (ext_rise),
        .ext_fall  (ext_fall),
        .state     (r_q.st),
        .step      (step)
    );

    always_comb begin
        r_d      = r_q;
        err_any  = err_overrun | err_framing | err_parity;
        can_load = tx_en & ~r_q.dre & ~err_any;
        nxt_idx  = r_q.bit_idx + 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (can_load) begin
                    r_d.shift = r_q.hold;
                    r_d.dre   = 1'b1;
                    r_d.st    = ST_ARM;
                end
            end
            ST_ARM: begin
                if (step) begin
                    r_d.sck     = 1'b0;
                    r_d.txd     = r_q.shift[0];
                    r_d.bit_idx = '0;
                    r_d.st      = ST_LOW;
                end
            end
            ST_LOW: begin
                if (step) begin
                    r_d.sck = 1'b1;
                    if (r_q.bit_idx == LAST_BIT) begin
                        if (can_load) begin
                            // Hand-off: next frame's first fall comes on the next step.
                            r_d.shift = r_q.hold;
                            r_d.dre   = 1'b1;
                            r_d.st    = ST_ARM;
                        end else begin
                            r_d.tend = 1'b1;
                            r_d.st   = ST_IDLE;
                        end
                    end else begin
                        r_d.st = ST_HIGH;
                    end
                end
            end
            ST_HIGH: begin
                if (step) begin
                    r_d.sck     = 1'b0;
                    r_d.bit_idx = nxt_idx;
                    r_d.txd     = r_q.shift[nxt_idx];
                    r_d.st      = ST_LOW;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // A new byte in the holding register overrides any same-cycle set.
        if (wr_en) begin
            r_d.hold = wr_data;
            r_d.dre  = 1'b0;
            r_d.tend = 1'b0;
        end

        // Disabled: park everything, keep the last data level.
        if (!tx_en) begin
            r_d.st   = ST_IDLE;
            r_d.dre  = 1'b1;
            r_d.tend = 1'b1;
            r_d.sck  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, hold: '0, shift: '0, bit_idx: '0,
                     dre: 1'b1, tend: 1'b1, txd: 1'b1, sck: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign txd       = r_q.txd;
    assign sck_out   = ext_mode | r_q.sck;
    assign dre_flag  = r_q.dre;
    assign tend_flag = r_q.tend;
    assign irq_empty = r_q.dre & int_en_empty;
    assign irq_end   = r_q.tend & int_en_end;

endmodule

// File: rtl/sync_tx_chk.sv
module sync_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_en,
    input logic ext_mode,
    input logic err_overrun,
    input logic err_framing,
    input logic err_parity,
    input logic int_en_empty,
    input logic int_en_end,
    input logic txd,
    input logic sck_out,
    input logic dre_flag,
    input logic tend_flag,
    input logic irq_empty,
    input logic irq_end
);

    logic err_seen;
    assign err_seen = err_overrun | err_framing | err_parity;

    a_r1_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_en) |=> !dre_flag);

    a_r2_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dre_flag) && int_en_empty) |-> irq_empty);

    a_r3_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !$stable(txd)) |-> !sck_out);

    a_r6_hold_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (tend_flag && $past(tend_flag)) |-> $stable(txd));

    a_r7_end_request: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tend_flag) && int_en_end) |-> irq_end);

    a_r8_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
        tend_flag |-> sck_out);

    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (dre_flag && tend_flag && sck_out));

    a_r10_error_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && err_seen && !dre_flag) |=> !dre_flag);

endmodule

bind sync_tx_engine sync_tx_chk u_chk (.*);

// File: tb/sync_tx_engine_tb.sv
module sync_tx_engine_tb;

    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic       ext_mode = 1'b0;
    logic       baud_tick = 1'b0;
    logic       ext_sck_in = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       err_overrun = 1'b0;
    logic       err_framing = 1'b0;
    logic       err_parity = 1'b0;
    logic       int_en_empty = 1'b0;
    logic       int_en_end = 1'b0;
    logic       txd, sck_out, dre_flag, tend_flag, irq_empty, irq_end;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_q[$];

    // monitor state
    int   cyc = 0;
    int   int_rises = 0;
    int   gap_err = 0;
    int   tend_rises = 0;
    int   ext_sck_low = 0;
    int   last_rise = 0;
    bit   last_valid = 0;
    logic obs_prev = 1'b1;
    logic sck_prev = 1'b1;
    logic tend_prev = 1'b1;
    logic [7:0] cur = '0;
    int   nbits = 0;

    always #5 clk = ~clk;

    sync_tx_engine u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (tx_en),
        .ext_mode     (ext_mode),
        .baud_tick    (baud_tick),
        .ext_sck_in   (ext_sck_in),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .err_overrun  (err_overrun),
        .err_framing  (err_framing),
        .err_parity   (err_parity),
        .int_en_empty (int_en_empty),
        .int_en_end   (int_en_end),
        .txd          (txd),
        .sck_out      (sck_out),
        .dre_flag     (dre_flag),
        .tend_flag    (tend_flag),
        .irq_empty    (irq_empty),
        .irq_end      (irq_end)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // baud tick: one cycle high every TICK_DIV cycles
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    // monitor: collects bits on the rising serial clock, pops the scoreboard
    always @(negedge clk) begin
        logic obs;
        cyc++;
        if (rst_n) begin
            if (!sck_out && sck_prev == 1'b0 && ext_mode) ext_sck_low++;
            if (ext_mode && !sck_out) ext_sck_low++;
            if (!ext_mode && sck_out && !sck_prev) begin
                int_rises++;
                if (last_valid && (cyc - last_rise) != 2 * TICK_DIV) gap_err++;
                last_rise  = cyc;
                last_valid = 1;
            end
            if (tend_flag) last_valid = 0;
            if (tend_flag && !tend_prev) tend_rises++;
            obs = ext_mode ? ext_sck_in : sck_out;
            if (obs && !obs_prev) begin
                cur = {txd, cur[7:1]};
                nbits++;
                if (nbits == 8) begin
                    nbits = 0;
                    if (exp_q.size() == 0) begin
                        chk(0, "R3", "unexpected frame", cur, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(cur == e, "R3", "frame data", cur, e);
                    end
                end
            end
            obs_prev = obs;
        end
        sck_prev  = sck_out;
        tend_prev = tend_flag;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    task automatic raw_write(input logic [7:0] b);
        @(negedge clk);
        wr_data = b;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // driver: push expected byte, write, check flags one edge later
    task automatic send_byte(input logic [7:0] b);
        exp_q.push_back(b);
        raw_write(b);
        chk(dre_flag == 1'b0, "R1", "empty flag after write", dre_flag, 0);
        chk(tend_flag == 1'b0, "R12", "end flag after write", tend_flag, 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tend_flag) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ext_sck_in = 1'b0;
            repeat (8) @(negedge clk);
            ext_sck_in = 1'b1;
            repeat (8) @(negedge clk);
        end
    endtask

    initial begin
        int rises0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(dre_flag == 1'b1, "R8", "reset empty flag", dre_flag, 1);
        chk(tend_flag == 1'b1, "R8", "reset end flag", tend_flag, 1);
        chk(sck_out == 1'b1 && txd == 1'b1, "R8", "reset sck/txd", {sck_out, txd}, 3);

        // single frame, bit 7 = 1, interrupts enabled
        int_en_empty = 1'b1;
        int_en_end   = 1'b1;
        send_byte(8'hA5);
        chk(irq_empty == 1'b0, "R2", "empty request while full", irq_empty, 0);
        @(negedge clk);
        chk(dre_flag == 1'b1, "R2", "empty flag after load", dre_flag, 1);
        chk(irq_empty == 1'b1, "R2", "empty request after load", irq_empty, 1);
        wait_idle();
        chk(txd == 1'b1, "R6", "txd holds bit7=1", txd, 1);
        chk(sck_out == 1'b1, "R8", "sck parked high", sck_out, 1);
        chk(irq_end == 1'b1, "R7", "end request enabled", irq_end, 1);
        chk(int_rises == 8, "R4", "rising edges per frame", int_rises, 8);
        chk(exp_q.size() == 0, "R3", "frame consumed", exp_q.size(), 0);
        chk(gap_err == 0, "R4", "half-period = one tick", gap_err, 0);

        // bit 7 = 0, end request disabled
        int_en_end = 1'b0;
        send_byte(8'h3C);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(txd == 1'b0, "R6", "txd holds bit7=0", txd, 0);
        chk(irq_end == 1'b0, "R7", "end request masked", irq_end, 0);
        chk(int_rises == 16, "R4", "rising edges two frames", int_rises, 16);

        // back-to-back burst
        tend_rises = 0;
        send_byte(8'h11);
        @(negedge clk);
        send_byte(8'hC3);
        while (!dre_flag) @(negedge clk);
        send_byte(8'h7E);
        wait_idle();
        chk(gap_err == 0, "R5", "no gap between frames", gap_err, 0);
        chk(tend_rises == 1, "R5", "end flag rises once", tend_rises, 1);
        chk(int_rises == 40, "R5", "rising edges in burst", int_rises, 40);
        chk(exp_q.size() == 0, "R5", "burst consumed", exp_q.size(), 0);
        chk(txd == 1'b0, "R6", "txd after burst", txd, 0);

        // error flags inhibit start
        rises0 = int_rises;
        err_framing = 1'b1;
        send_byte(8'h5A);
        repeat (60) @(negedge clk);
        chk(dre_flag == 1'b0, "R10", "empty flag held low", dre_flag, 0);
        chk(int_rises == rises0, "R10", "no clock while error", int_rises, rises0);
        chk(sck_out == 1'b1, "R10", "sck idle while error", sck_out, 1);
        err_framing = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0, "R10", "sent after errors clear", exp_q.size(), 0);
        chk(int_rises == rises0 + 8, "R10", "one frame after clear", int_rises, rises0 + 8);

        // disabled engine
        rises0 = int_rises;
        tx_en = 1'b0;
        raw_write(8'hFF);
        chk(dre_flag == 1'b1 && tend_flag == 1'b1, "R9", "flags held when disabled",
            {dre_flag, tend_flag}, 3);
        repeat (40) @(negedge clk);
        tx_en = 1'b1;
        repeat (80) @(negedge clk);
        chk(int_rises == rises0, "R9", "no frame from disabled write", int_rises, rises0);
        chk(dre_flag == 1'b1, "R9", "empty flag after enable", dre_flag, 1);

        // external clock mode
        ext_mode = 1'b1;
        ext_sck_low = 0;
        repeat (4) @(negedge clk);
        send_byte(8'h96);
        repeat (6) @(negedge clk);
        ext_pulses(8);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R11", "external frame consumed", exp_q.size(), 0);
        chk(tend_flag == 1'b1, "R11", "end after eighth pulse", tend_flag, 1);
        chk(txd == 1'b1, "R6", "txd holds bit7 external", txd, 1);
        chk(ext_sck_low == 0, "R11", "sck_out stays high", ext_sck_low, 0);
        chk(int_rises == rises0, "R11", "no internal clock", int_rises, rises0);

        finish_run();
    end

endmodule